// File: doc/BRIEF.md
# Delayed SRAM Write Sequencer for a Search Coprocessor

This block accepts single-beat write commands that a host aims at the off-chip SRAM holding associative data next to a search coprocessor. The command's first cycle is split into two clock beats, A and B. Beat A carries the opcode, the device-select field, the address-space select and the address. Beat B must repeat the write opcode with valid high. The block then ignores the bus for two more beats and can take a new command on the fourth beat.

An accepted write is addressed to this device and to the SRAM space, and is not a burst. Such a write enters a delay line. It leaves the delay line on the SRAM bus after exactly the search latency picked by a 2-bit table-size setting, so SRAM writes and search results keep one timing. Writes that overlap in the delay line come out in order. The 22-bit SRAM address joins two high bits from the command word with twenty bits from the data bus.

The command side is a valid/ready stream. A beat A counts only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` drops for the next three beats and rises again by itself, and the host applies back-pressure only by waiting for it. Configuration, device ID and the SRAM outputs are plain pins with no handshake.

Top module: `assoc_sram_wr_seq`

## Requirements
- R1: A command starts when `cmd_valid`=1, `cmd_ready`=1 and `cmd_word[1:0]`=2'b01 (write). On the next beat (B), `cmd_valid`=1 with opcode 2'b01 must repeat. If beat B does not repeat it, the command is dropped with no SRAM write, and `cmd_ready` is high again on the beat after B.
- R2: Only `dq_in[20:19]`=2'b10 (SRAM space) in beat A can lead to an SRAM write. Any other value produces none.
- R3: Only `dq_in[25:21]` equal to `dev_id` in beat A can lead to an SRAM write.
- R4: The SRAM address is {`cmd_word[8:7]`, `dq_in[45:26]`}, both taken in beat A.
- R5: With `cmd_word[2]`=1 (burst) in beat A, no SRAM write is issued. If the command is otherwise valid and addressed to this device's SRAM space, `burst_err` is high for exactly the one beat after B.
- R6: After an accepted beat B, `cmd_ready` is low for beat B and the two following beats. Inputs during those beats have no effect. `cmd_ready` is high four beats after beat A.
- R7: A write whose beat B is in cycle n reaches the SRAM bus in cycle n+1+L. L is 4, 5, 6 or 6 for `cfg_tsize` 00, 01, 10 or 11.
- R8: Writes that overlap in the delay line all reach the SRAM bus, in command order, each at its own R7 time.
- R9: For each write, `sram_ce_n` and `sram_we_n` are low together for exactly one cycle, with the write's address on `sram_addr`.
- R10: In every cycle with no write due, `sram_ce_n`=`sram_we_n`=1 and `sram_addr`=0. This holds after reset too, with `cmd_ready`=1 and `burst_err`=0.
- R11: Reset empties the delay line, so a write in flight at reset never reaches the SRAM bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tsize | input | 2 | Table-size setting that picks the latency |
| dev_id | input | 5 | This device's select value |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Block can take a beat A |
| cmd_word | input | 9 | [1:0] opcode, [2] burst, [8:7] address high |
| dq_in | input | 68 | Data bus: [20:19] space, [25:21] device, [45:26] address low |
| sram_addr | output | 22 | SRAM address, 0 when idle |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| burst_err | output | 1 | One-beat flag for a rejected burst write |

## Verification
The scoreboard records the cycle each write is due and fails on a strobe one cycle early or late. A wrong tap in the latency map shows up this way for each table-size code, including 11. Writes are issued back to back at the longest latency, so several are in flight together. A delay line that dropped, merged or reordered them would give missing strobes or the wrong addresses. Commands with the wrong space, the wrong device, the burst bit, or a bad beat B must produce no strobe at all, and a design that ignored any of those qualifiers would issue a stray write. Garbage write commands sent during the ignored beats would become extra writes in a decoder that accepted early. A reset while a write is in flight would let that write escape if the pipeline were not cleared.

// File: rtl/aswq_pkg.sv
package aswq_pkg;

  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_BEAT_B = 2'd1,
    DS_GAP1 = 2'd2,
    DS_GAP2 = 2'd3
  } dec_state_e;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] SPACE_SRAM = 2'b10;

  // table-size code to search latency in beats
  function automatic int unsigned tsize_to_lat(input logic [1:0] ts);
    case (ts)
      2'b00: return 4;
      2'b01: return 5;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/swq_cmd_decode.sv
module swq_cmd_decode
  import aswq_pkg::*;
#(
  parameter int DQ_W = 68,
  parameter int ID_W = 5,
  parameter int ADDR_W = 22,
  parameter int SPACE_LSB = 19,
  parameter int ID_LSB = 21,
  parameter int LO_LSB = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [8:0]        cmd_word,
  input  logic [DQ_W-1:0]   dq,
  input  logic [ID_W-1:0]   dev_id,
  output logic              cmd_ready,
  output logic              issue_v,
  output logic [ADDR_W-1:0] issue_addr,
  output logic              burst_hit
);

  localparam int LO_W = ADDR_W - 2;
  localparam int LO_MSB = LO_LSB + LO_W - 1;

  dec_state_e        state_q;
  logic [1:0]        hi_q;
  logic [LO_W-1:0]   lo_q;
  logic              match_q;
  logic              burst_q;
  logic              wr_beat;
  logic              beat_b_ok;
  logic              unused_bits;

  assign wr_beat = cmd_valid && (cmd_word[1:0] == OP_WRITE);
  assign unused_bits = ^{cmd_word[6:3], dq[DQ_W-1:LO_MSB+1], dq[SPACE_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      hi_q    <= '0;
      lo_q    <= '0;
      match_q <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      case (state_q)
        DS_IDLE: begin
          if (wr_beat) begin
            hi_q    <= cmd_word[8:7];
            lo_q    <= dq[LO_MSB:LO_LSB];
            match_q <= (dq[SPACE_LSB+1:SPACE_LSB] == SPACE_SRAM) &&
                       (dq[ID_LSB+ID_W-1:ID_LSB] == dev_id);
            burst_q <= cmd_word[2];
            state_q <= DS_BEAT_B;
          end
        end
        DS_BEAT_B: state_q <= wr_beat ? DS_GAP1 : DS_IDLE;
        DS_GAP1:   state_q <= DS_GAP2;
        default:   state_q <= DS_IDLE;
      endcase
    end
  end

  assign beat_b_ok  = (state_q == DS_BEAT_B) && wr_beat && match_q;
  assign cmd_ready  = (state_q == DS_IDLE);
  assign issue_v    = beat_b_ok && !burst_q;
  assign burst_hit  = beat_b_ok && burst_q;
  assign issue_addr = {hi_q, lo_q};

endmodule

// File: rtl/swq_delay_line.sv
module swq_delay_line #(
  parameter int W = 22,
  parameter int DEPTH = 7,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [W-1:0]     in_data,
  input  logic [SEL_W-1:0] tap,
  output logic             out_v,
  output logic [W-1:0]     out_data
);

  logic [DEPTH-1:0] v_q;
  logic [W-1:0]     d_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      d_q[0] <= '0;
    end else begin
      v_q[0] <= in_v;
      d_q[0] <= in_v ? in_data : '0;
    end
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[k] <= 1'b0;
        d_q[k] <= '0;
      end else begin
        v_q[k] <= v_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  always_comb begin
    out_v    = 1'b0;
    out_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (tap == SEL_W'(k)) begin
        out_v    = v_q[k];
        out_data = d_q[k];
      end
    end
  end

endmodule

// File: rtl/swq_sram_drive.sv
module swq_sram_drive #(
  parameter int ADDR_W = 22
) (
  input  logic              due_v,
  input  logic [ADDR_W-1:0] due_addr,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n
);

  assign sram_ce_n = ~due_v;
  assign sram_we_n = ~due_v;
  assign sram_addr = due_v ? due_addr : '0;

endmodule

// File: rtl/assoc_sram_wr_seq.sv
module assoc_sram_wr_seq
  import aswq_pkg::*;
#(
  parameter int DQ_W = 68,
  parameter int ID_W = 5,
  parameter int ADDR_W = 22,
  parameter int MAX_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_tsize,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [8:0]        cmd_word,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              burst_err
);

  localparam int DEPTH = MAX_LAT + 1;
  localparam int SEL_W = $clog2(DEPTH);

  logic              issue_v;
  logic [ADDR_W-1:0] issue_addr;
  logic              burst_hit;
  logic              due_v;
  logic [ADDR_W-1:0] due_addr;
  logic [SEL_W-1:0]  tap;

  assign tap = SEL_W'(tsize_to_lat(cfg_tsize));

  swq_cmd_decode #(
    .DQ_W(DQ_W), .ID_W(ID_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .dq(dq_in), .dev_id(dev_id), .cmd_ready(cmd_ready),
    .issue_v(issue_v), .issue_addr(issue_addr), .burst_hit(burst_hit)
  );

  swq_delay_line #(
    .W(ADDR_W), .DEPTH(DEPTH)
  ) u_dly (
    .clk(clk), .rst_n(rst_n), .in_v(issue_v), .in_data(issue_addr),
    .tap(tap), .out_v(due_v), .out_data(due_addr)
  );

  swq_sram_drive #(
    .ADDR_W(ADDR_W)
  ) u_drv (
    .due_v(due_v), .due_addr(due_addr), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_err <= 1'b0;
    else        burst_err <= burst_hit;
  end

endmodule

// File: rtl/assoc_sram_wr_seq_chk.sv
module assoc_sram_wr_seq_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [8:0]        cmd_word,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              burst_err
);

  AST_STROBE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n) else $error("strobe longer than one beat"); // R9

  AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n == sram_we_n) else $error("ce/we mismatch"); // R9

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we_n |-> (sram_addr == '0)) else $error("address not idle"); // R10

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_word[1:0] == 2'b01) |=> !cmd_ready)
    else $error("ready not dropped"); // R6

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |=> !burst_err) else $error("burst error too long"); // R5

endmodule

bind assoc_sram_wr_seq assoc_sram_wr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_assoc_sram_wr_seq.sv
`timescale 1ns/1ps
module sim_assoc_sram_wr_seq;

  localparam logic [4:0] DEV = 5'd13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_tsize = 2'b00;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [8:0]  cmd_word = '0;
  logic [67:0] dq_in = '0;
  logic [21:0] sram_addr;
  logic        sram_ce_n, sram_we_n, burst_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int exp_cyc[$];
  logic [21:0] exp_addr[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assoc_sram_wr_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tsize(cfg_tsize), .dev_id(DEV),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .dq_in(dq_in), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .burst_err(burst_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [67:0] mk_dq(input logic [1:0] sp, input logic [4:0] id,
                                        input logic [19:0] lo);
    logic [67:0] v;
    v = {22'h2A5A5A, lo, id, sp, 19'h51234};
    return v;
  endfunction

  function automatic int lat_of(input logic [1:0] ts);
    return (ts == 2'b00) ? 4 : (ts == 2'b01) ? 5 : 6;
  endfunction

  // monitor: compares SRAM strobes against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!sram_we_n || !sram_ce_n) begin
        if (exp_cyc.size() == 0) begin
          chk(0, "R2/R3/R5 unexpected SRAM write", sram_addr, 0);
        end else begin
          chk(sram_ce_n == sram_we_n, "R9 strobes paired", sram_ce_n, sram_we_n);
          chk(exp_cyc[0] == cyc, "R7 strobe cycle", cyc, exp_cyc[0]);
          chk(exp_addr[0] == sram_addr, "R4 address", sram_addr, exp_addr[0]);
          void'(exp_cyc.pop_front());
          void'(exp_addr.pop_front());
        end
      end else begin
        chk(sram_addr == 0, "R10 idle address", sram_addr, 0);
        if (exp_cyc.size() != 0 && exp_cyc[0] < cyc) begin
          chk(0, "R8 missing SRAM write", 0, exp_addr[0]);
          void'(exp_cyc.pop_front());
          void'(exp_addr.pop_front());
        end
      end
    end
  end

  // driver: one full command; called at a negedge
  task automatic send(input bit bval, input logic [1:0] bop, input logic [1:0] sp,
                      input logic [4:0] id, input bit burst, input logic [1:0] hi,
                      input logic [19:0] lo);
    bit phb, hit;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {hi, 4'b0000, burst, 2'b01};
    dq_in     = mk_dq(sp, id, lo);
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R6 ready low in beat B", cmd_ready, 0);
    cmd_valid = bval;
    cmd_word[1:0] = bop;
    phb = bval && (bop == 2'b01);
    hit = phb && (sp == 2'b10) && (id == DEV);
    if (hit && !burst) begin
      exp_cyc.push_back(cyc + 1 + lat_of(cfg_tsize));
      exp_addr.push_back({hi, lo});
    end
    @(negedge clk);
    chk(burst_err == (hit && burst), "R5 burst_err", burst_err, hit && burst);
    if (phb) begin
      chk(cmd_ready == 1'b0, "R6 ready low gap1", cmd_ready, 0);
      cmd_valid = 1'b1;
      cmd_word  = {2'b11, 4'b0000, 1'b0, 2'b01};
      dq_in     = mk_dq(2'b10, DEV, 20'hBAD01);
      @(negedge clk);
      chk(burst_err == 1'b0, "R5 burst_err one beat", burst_err, 0);
      chk(cmd_ready == 1'b0, "R6 ready low gap2", cmd_ready, 0);
      dq_in     = mk_dq(2'b10, DEV, 20'hBAD02);
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R6 ready back", cmd_ready, 1);
    end else begin
      chk(cmd_ready == 1'b1, "R1 ready after bad beat B", cmd_ready, 1);
    end
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
    chk(exp_cyc.size() == 0, "R8 scoreboard drained", exp_cyc.size(), 0);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10 reset ready", cmd_ready, 1);
    chk(sram_we_n && sram_ce_n, "R10 reset strobes high", {sram_ce_n, sram_we_n}, 3);
    chk(burst_err == 1'b0, "R10 reset burst_err", burst_err, 0);

    // basic writes, latency 4
    send(1, 2'b01, 2'b10, DEV, 0, 2'b00, 20'h00001);
    send(1, 2'b01, 2'b10, DEV, 0, 2'b11, 20'hFFFFF);
    send(1, 2'b01, 2'b10, DEV, 0, 2'b10, 20'h5A5A5);
    drain();
    // qualifiers that must block the write
    send(1, 2'b01, 2'b01, DEV, 0, 2'b01, 20'h11111);        // R2
    send(1, 2'b01, 2'b11, DEV, 0, 2'b01, 20'h22222);        // R2
    send(1, 2'b01, 2'b10, DEV ^ 5'd1, 0, 2'b01, 20'h33333); // R3
    send(1, 2'b01, 2'b10, DEV, 1, 2'b01, 20'h44444);        // R5
    send(1, 2'b01, 2'b10, DEV ^ 5'd4, 1, 2'b01, 20'h55555); // R5 no flag
    send(0, 2'b01, 2'b10, DEV, 0, 2'b01, 20'h66666);        // R1 beat B invalid
    send(1, 2'b10, 2'b10, DEV, 0, 2'b01, 20'h77777);        // R1 beat B wrong op
    send(1, 2'b01, 2'b10, DEV, 0, 2'b01, 20'h0ABCD);        // R1 recovers
    drain();
    // overlapping writes at each table size
    for (int t = 1; t < 4; t++) begin
      cfg_tsize = 2'(t);
      @(negedge clk);
      for (int i = 0; i < 4; i++)
        send(1, 2'b01, 2'b10, DEV, 0, 2'(i), 20'(32'h1000 * (t + 1) + i)); // R8 R7
      drain();
    end
    // reset while a write is in flight
    cfg_tsize = 2'b10;
    @(negedge clk);
    send(1, 2'b01, 2'b10, DEV, 0, 2'b01, 20'hDEAD0);
    rst_n = 1'b0;
    exp_cyc.delete();
    exp_addr.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(sram_we_n && sram_ce_n, "R11 no write after reset", {sram_ce_n, sram_we_n}, 3);
    end
    send(1, 2'b01, 2'b10, DEV, 0, 2'b10, 20'h0BEEF);
    drain();
    finish_run();
  end

endmodule